// File: doc/BRIEF.md
# Pad Connectivity Test Wrapper

This block sits between a chip's functional logic and its I/O pads and adds a board-level contact test. When the active-low board reset is released, the block looks at two strap inputs (a frame strap and a data-bit-0 strap). If both are low at that moment, it enters chain test mode. Otherwise it stays in, or returns to, normal mode. The choice is held until the next reset release. A separate synchronous power-on clear forces normal mode.

In chain test mode every chained pad is cut off from the functional logic and turned into an input. The pad inputs feed a serial XNOR cascade. The first stage combines pad 0 with pad 1, and each later stage combines the running result with the next pad. The final result drives one extra tail pad, whose output enable is forced on. A board tester can then drive the pads and watch a single pin, so an open or shorted pad shows up as a missing toggle.

In normal mode all pads, including the tail pad, carry their functional output, output-enable and input signals unchanged. The reset pin itself is not a chained pad.

Top module: `xnor_board_test`

## Requirements
- R1: While `por` is high at a clock edge, `test_mode` reads 0 after that edge, whatever the reset and strap inputs are.
- R2: When `rst_n` is sampled high at a clock edge after being sampled low at the previous edge, with `strap_frame` = 0 and `strap_d0` = 0 at that edge, `test_mode` reads 1 after that edge.
- R3: At such a rising reset edge, if `strap_frame` or `strap_d0` is 1, `test_mode` reads 0 after that edge.
- R4: `test_mode` keeps its value on every edge that is not a rising reset edge. This holds while `rst_n` is low and while `rst_n` stays high, even when the straps change.
- R5: While `test_mode` = 1, every bit of `pad_oe`, `pad_out` and `fn_in` is 0, and `fn_tail_in` is 0.
- R6: While `test_mode` = 1, `tail_pad_oe` is 1 and `tail_pad_out` is the chain result.
- R7: The chain result over N pad inputs equals the parity of the inputs XOR the parity of (N-1). Changing exactly one pad input therefore inverts `tail_pad_out`.
- R8: While `test_mode` = 0, `pad_out` = `fn_out` and `pad_oe` = `fn_oe`. Also `fn_in` = `pad_in`, `tail_pad_out` = `fn_tail_out`, `tail_pad_oe` = `fn_tail_oe` and `fn_tail_in` = `tail_pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on clear |
| rst_n | input | 1 | Active-low board reset; its release is the strap sampling point |
| strap_frame | input | 1 | Frame strap, sampled on reset release |
| strap_d0 | input | 1 | Data bit 0 strap, sampled on reset release |
| fn_out | input | N_PADS | Functional output values of the chained pads |
| fn_oe | input | N_PADS | Functional output enables of the chained pads |
| fn_in | output | N_PADS | Pad input values delivered to functional logic |
| pad_in | input | N_PADS | Values seen at the chained pads |
| pad_out | output | N_PADS | Values driven toward the chained pads |
| pad_oe | output | N_PADS | Output enables of the chained pads |
| fn_tail_out | input | 1 | Functional output of the tail pad |
| fn_tail_oe | input | 1 | Functional output enable of the tail pad |
| fn_tail_in | output | 1 | Tail pad input value delivered to functional logic |
| tail_pad_in | input | 1 | Value seen at the tail pad |
| tail_pad_out | output | 1 | Value driven toward the tail pad |
| tail_pad_oe | output | 1 | Output enable of the tail pad |
| test_mode | output | 1 | 1 while chain test mode is active |

## Verification
The only state is the mode bit and the delayed copy of the reset line. A wrong mode bit shows at once on every pad output and enable, within the same cycle as the bad update. A wrong delayed reset copy shows as a missed or spurious mode change on the cycle after a reset release. The bench therefore runs reset pulses with each strap combination and strap changes away from the release edge. It compares every output against a behavioural model at every cycle, so a fault is reported within one clock of its cause. The chain is checked against a parity formula under single-bit toggles and random patterns.

// File: rtl/xnor_board_test_pkg.sv
package xnor_board_test_pkg;
  typedef enum logic {
    MODE_FUNC  = 1'b0,
    MODE_CHAIN = 1'b1
  } bt_mode_e;
endpackage

// File: rtl/bt_mode_latch.sv
module bt_mode_latch
  import xnor_board_test_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  logic     rst_n,
  input  logic     strap_frame,
  input  logic     strap_d0,
  output bt_mode_e mode
);
  logic rst_q;
  logic release_edge;

  assign release_edge = rst_n & ~rst_q;

  always_ff @(posedge clk) begin
    if (por) begin
      rst_q <= rst_n;
      mode  <= MODE_FUNC;
    end else begin
      rst_q <= rst_n;
      if (release_edge) begin
        mode <= (!strap_frame && !strap_d0) ? MODE_CHAIN : MODE_FUNC;
      end
    end
  end
endmodule

// File: rtl/bt_pad_mux.sv
module bt_pad_mux (
  input  logic chain_en,
  input  logic fn_o,
  input  logic fn_e,
  output logic fn_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_e
);
  always_comb begin
    if (chain_en) begin
      pad_o = 1'b0;
      pad_e = 1'b0;
      fn_i  = 1'b0;
    end else begin
      pad_o = fn_o;
      pad_e = fn_e;
      fn_i  = pad_i;
    end
  end
endmodule

// File: rtl/bt_xnor_chain.sv
module bt_xnor_chain #(
  parameter int N_PADS = 8
) (
  input  logic [N_PADS-1:0] din,
  output logic              dout
);
  localparam int LAST = N_PADS - 1;
  logic [N_PADS-1:0] stage;

  assign stage[0] = din[0];
  for (genvar k = 1; k < N_PADS; k++) begin : g_stage
    assign stage[k] = ~(stage[k-1] ^ din[k]);
  end
  assign dout = stage[LAST];
endmodule

// File: rtl/xnor_board_test.sv
module xnor_board_test
  import xnor_board_test_pkg::*;
#(
  parameter int N_PADS = 8
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst_n,
  input  logic              strap_frame,
  input  logic              strap_d0,
  input  logic [N_PADS-1:0] fn_out,
  input  logic [N_PADS-1:0] fn_oe,
  output logic [N_PADS-1:0] fn_in,
  input  logic [N_PADS-1:0] pad_in,
  output logic [N_PADS-1:0] pad_out,
  output logic [N_PADS-1:0] pad_oe,
  input  logic              fn_tail_out,
  input  logic              fn_tail_oe,
  output logic              fn_tail_in,
  input  logic              tail_pad_in,
  output logic              tail_pad_out,
  output logic              tail_pad_oe,
  output logic              test_mode
);
  bt_mode_e mode;
  logic     chain_en;
  logic     chain_res;

  bt_mode_latch u_mode (
    .clk        (clk),
    .por        (por),
    .rst_n      (rst_n),
    .strap_frame(strap_frame),
    .strap_d0   (strap_d0),
    .mode       (mode)
  );

  assign chain_en  = (mode == MODE_CHAIN);
  assign test_mode = chain_en;

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    bt_pad_mux u_mux (
      .chain_en(chain_en),
      .fn_o    (fn_out[p]),
      .fn_e    (fn_oe[p]),
      .fn_i    (fn_in[p]),
      .pad_i   (pad_in[p]),
      .pad_o   (pad_out[p]),
      .pad_e   (pad_oe[p])
    );
  end

  bt_xnor_chain #(.N_PADS(N_PADS)) u_chain (
    .din (pad_in),
    .dout(chain_res)
  );

  always_comb begin
    if (chain_en) begin
      tail_pad_out = chain_res;
      tail_pad_oe  = 1'b1;
      fn_tail_in   = 1'b0;
    end else begin
      tail_pad_out = fn_tail_out;
      tail_pad_oe  = fn_tail_oe;
      fn_tail_in   = tail_pad_in;
    end
  end
endmodule

// File: rtl/chk_xnor_board_test.sv
module chk_xnor_board_test #(
  parameter int N_PADS = 8
) (
  input logic              clk,
  input logic              por,
  input logic              rst_n,
  input logic              strap_frame,
  input logic              strap_d0,
  input logic [N_PADS-1:0] fn_out,
  input logic [N_PADS-1:0] fn_oe,
  input logic [N_PADS-1:0] fn_in,
  input logic [N_PADS-1:0] pad_in,
  input logic [N_PADS-1:0] pad_out,
  input logic [N_PADS-1:0] pad_oe,
  input logic              tail_pad_out,
  input logic              tail_pad_oe,
  input logic              test_mode
);
  p_por_clear_r1: assert property (@(posedge clk) por |=> !test_mode);

  p_enter_r2: assert property (@(posedge clk) disable iff (por)
    ($rose(rst_n) && !strap_frame && !strap_d0) |=> test_mode);

  p_exit_r3: assert property (@(posedge clk) disable iff (por)
    ($rose(rst_n) && (strap_frame || strap_d0)) |=> !test_mode);

  p_hold_low_r4: assert property (@(posedge clk) disable iff (por)
    !rst_n |=> $stable(test_mode));

  p_iso_r5: assert property (@(posedge clk) disable iff (por)
    test_mode |-> (pad_oe == '0 && pad_out == '0 && fn_in == '0));

  p_tail_drive_r6: assert property (@(posedge clk) disable iff (por)
    test_mode |-> tail_pad_oe);

  p_toggle_r7: assert property (@(posedge clk) disable iff (por)
    (test_mode && $past(test_mode) && $countones(pad_in ^ $past(pad_in)) == 1)
      |-> tail_pad_out != $past(tail_pad_out));

  p_pass_r8: assert property (@(posedge clk) disable iff (por)
    !test_mode |-> (pad_out == fn_out && pad_oe == fn_oe && fn_in == pad_in));
endmodule

bind xnor_board_test chk_xnor_board_test #(.N_PADS(N_PADS)) u_chk (
  .clk         (clk),
  .por         (por),
  .rst_n       (rst_n),
  .strap_frame (strap_frame),
  .strap_d0    (strap_d0),
  .fn_out      (fn_out),
  .fn_oe       (fn_oe),
  .fn_in       (fn_in),
  .pad_in      (pad_in),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .tail_pad_out(tail_pad_out),
  .tail_pad_oe (tail_pad_oe),
  .test_mode   (test_mode)
);

// File: tb/sim_xnor_board_test.sv
module sim_xnor_board_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         por = 1'b1;
  logic         rst_n = 1'b0;
  logic         strap_frame = 1'b1;
  logic         strap_d0 = 1'b1;
  logic [N-1:0] fn_out = '0;
  logic [N-1:0] fn_oe = '0;
  logic [N-1:0] fn_in;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic         fn_tail_out = 1'b0;
  logic         fn_tail_oe = 1'b0;
  logic         fn_tail_in;
  logic         tail_pad_in = 1'b0;
  logic         tail_pad_out;
  logic         tail_pad_oe;
  logic         test_mode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  bit m_mode = 0;
  bit m_prev = 0;

  xnor_board_test #(.N_PADS(N)) u0 (
    .clk(clk), .por(por), .rst_n(rst_n),
    .strap_frame(strap_frame), .strap_d0(strap_d0),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .fn_tail_out(fn_tail_out), .fn_tail_oe(fn_tail_oe), .fn_tail_in(fn_tail_in),
    .tail_pad_in(tail_pad_in), .tail_pad_out(tail_pad_out), .tail_pad_oe(tail_pad_oe),
    .test_mode(test_mode)
  );

  always #2 clk = ~clk;

  // behavioural reference: a mode flag updated when reset goes from low to high
  always @(posedge clk) begin
    if (por) begin
      m_mode = 0;
    end else if (rst_n && !m_prev) begin
      m_mode = (strap_frame == 0) && (strap_d0 == 0);
    end
    m_prev = rst_n;
    cycles++;
  end

  function automatic bit chain_ref(input logic [N-1:0] v);
    int ones = 0;
    for (int i = 0; i < N; i++) if (v[i]) ones++;
    return ((ones + N - 1) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R2 R3 R4 mode", N'(test_mode), N'(m_mode));
      if (m_mode) begin
        chk("R5 pad_oe", pad_oe, '0);
        chk("R5 pad_out", pad_out, '0);
        chk("R5 fn_in", fn_in, '0);
        chk("R5 fn_tail_in", N'(fn_tail_in), '0);
        chk("R6 tail_oe", N'(tail_pad_oe), N'(1));
        chk("R6 R7 tail_out", N'(tail_pad_out), N'(chain_ref(pad_in)));
      end else begin
        chk("R8 pad_out", pad_out, fn_out);
        chk("R8 pad_oe", pad_oe, fn_oe);
        chk("R8 fn_in", fn_in, pad_in);
        chk("R8 tail_out", N'(tail_pad_out), N'(fn_tail_out));
        chk("R8 tail_oe", N'(tail_pad_oe), N'(fn_tail_oe));
        chk("R8 tail_in", N'(fn_tail_in), N'(tail_pad_in));
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shuffle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fn_out = N'($urandom); fn_oe = N'($urandom); pad_in = N'($urandom);
      fn_tail_out = 1'($urandom); fn_tail_oe = 1'($urandom); tail_pad_in = 1'($urandom);
    end
  endtask

  task automatic reset_pulse(input logic sf, input logic sd);
    @(negedge clk); rst_n = 0;
    wait_cyc(2);
    strap_frame = ~sf; strap_d0 = ~sd;   // R4: straps move while reset is low
    wait_cyc(1);
    strap_frame = sf; strap_d0 = sd; rst_n = 1;
    wait_cyc(2);
    strap_frame = ~sf; strap_d0 = ~sd;   // R4: straps move with reset high
    wait_cyc(2);
  endtask

  task automatic walk_ones;
    // R7: single-bit toggles in test mode
    for (int b = 0; b < N; b++) begin
      @(negedge clk); pad_in[b] = ~pad_in[b];
    end
    for (int b = 0; b < N; b++) begin
      @(negedge clk); pad_in = '0; pad_in[b] = 1'b1;
    end
    @(negedge clk); pad_in = '1;
  endtask

  initial begin
    fork
      begin
        wait_cyc(4);
        strap_frame = 0; strap_d0 = 0;       // R1: por dominates a release
        rst_n = 1;
        wait_cyc(2);
        @(negedge clk); por = 0; rst_n = 0;
        strap_frame = 1; strap_d0 = 1;
        wait_cyc(2);
        @(negedge clk); rst_n = 1;           // R3: both straps high
        shuffle(6);
        reset_pulse(0, 0);                   // R2
        walk_ones();
        shuffle(8);
        reset_pulse(1, 0);                   // R3 frame high
        shuffle(6);
        reset_pulse(0, 0);
        reset_pulse(0, 1);                   // R3 data bit high
        shuffle(4);
        reset_pulse(0, 0);
        shuffle(4);
        @(negedge clk); por = 1;             // R1 from test mode
        wait_cyc(2);
        @(negedge clk); por = 0;
        shuffle(4);
        reset_pulse(0, 0);
        walk_ones();
        wait_cyc(2);
      end
      begin
        wait (cycles > 5000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
      end
    join_any
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule